// File: doc/BRIEF.md
# Data Object Exchange Mailbox Register Block

This block is the device-side register set of a mailbox through which host software swaps structured messages with a function. Software pushes a request object one 32-bit dword at a time into a write mailbox, then sets a start bit in the control register. A built-in responder stub stays busy for a fixed latency, then offers a response object that echoes the request word for word. Software reads the current response dword from the read mailbox and writes any value to that mailbox to move on to the next dword. Every object starts with two header dwords, and the second one holds the object length in dwords, header included. Because the stub echoes the request, the response header keeps the same length.

The response-ready flag means that the whole response object is available. It drops only after the last dword has been consumed, or when an abort or a function reset removes the object. An abort runs for a fixed number of cycles. During that time the block reports busy. When the abort ends, the ready and error flags are cleared, but the interrupt status flag is left as it was. Three events raise an interrupt: a response becoming ready, the error flag setting, and busy dropping. Interrupts are gated by an enable bit. Busy dropping has no status flag of its own.

Register map (2-bit address): 0 = control, 1 = status, 2 = write mailbox, 3 = read mailbox.

Top module: `objx_mailbox`

## Requirements
- R1: After reset, the control read-back and the status register read as 0, the read mailbox reads 0 and `irq` is low. Control bits: bit 0 abort, bit 1 go, bit 2 interrupt enable (only bit 2 reads back). Status bits: bit 0 busy, bit 1 interrupt status, bit 2 error, bit 3 response ready.
- R2: A go write that is accepted sets busy from the next cycle. Busy stays set for RESP_LAT cycles after the write edge. In the cycle that busy clears, ready sets.
- R3: The response returns the accepted request dwords in the order they were written. Each write to the read mailbox advances to the next dword. Ready clears after the write that consumes the last dword.
- R4: While ready is clear, the read mailbox reads 0, and writes to it change nothing.
- R5: Error sets on any of three go conditions: go while busy, go with fewer than two dwords in the request buffer, or go after more than DEPTH dwords were written. The faulty request is dropped. A go while busy does not disturb the request already in flight.
- R6: An abort (control bit 0) holds busy for ABORT_CYC cycles. When it finishes, ready, error and busy all read 0 and the request buffer is emptied.
- R7: An abort never clears interrupt status.
- R8: A `func_rst` pulse clears ready, busy, error, interrupt status, interrupt enable and any transfer in progress, including a response that has only been partly read. The clearing shows from the next cycle.
- R9: When interrupt enable is set, a rise of ready, a rise of error or a fall of busy gives a one-cycle `irq` pulse in the next cycle and sets interrupt status. When enable is clear, none of these events raise `irq` or set interrupt status.
- R10: Writing 1 to status bit 1 clears interrupt status. If a new interrupt falls in the same cycle as that write, interrupt status stays set.
- R11: Writes to the write mailbox while busy is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high conventional reset |
| func_rst | input | 1 | Synchronous function-level reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 write mailbox, 3 read mailbox |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two functions can meet in one cycle: software clearing interrupt status by writing 1 to it, and the block setting interrupt status when a new response becomes ready. The bench issues a go and counts cycles so that the status clear write lands on the exact edge where the ready-driven interrupt sets. It then expects interrupt status to read 1, and to read 0 only after a second clear. A second pairing is a go that arrives while a request is still running. Here error must set while the in-flight response comes back intact.

// File: rtl/objx_pkg.sv
package objx_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_WMB  = 2'd2,
        SEL_RMB  = 2'd3
    } sel_e;

    localparam int CTL_ABORT = 0;
    localparam int CTL_GO    = 1;
    localparam int CTL_IEN   = 2;
    localparam int STAT_INT  = 1;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_ABORT
    } eng_e;

    typedef struct packed {
        logic ready;
        logic error;
        logic int_st;
        logic busy;
    } stat_t;

    function automatic logic [DW-1:0] stat_word(stat_t s);
        return {{(DW-4){1'b0}}, s};
    endfunction

    function automatic logic [DW-1:0] ctrl_word(logic ien);
        return {{(DW-3){1'b0}}, ien, 2'b00};
    endfunction

endpackage

// File: rtl/objx_req_buf.sv
module objx_req_buf
    import objx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    din,
    input  logic             discard,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic [DW-1:0]    data [DEPTH]
);

    logic full;
    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (clr || discard) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && !clr && !discard && count == CNT_W'(g)) begin
                data[g] <= din;
            end
        end
    end

endmodule

// File: rtl/objx_resp_buf.sv
module objx_resp_buf
    import objx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [DW-1:0]    load_data [DEPTH],
    input  logic [CNT_W-1:0] load_len,
    input  logic             pop,
    output logic             ready,
    output logic [DW-1:0]    cur
);

    logic [DW-1:0]    mem [DEPTH];
    logic [CNT_W-1:0] len_q;
    logic [IDX_W-1:0] ptr_q;
    logic             last;

    assign last = (CNT_W'(ptr_q) + 1'b1 == len_q);
    assign cur  = ready ? mem[ptr_q] : '0;

    always_ff @(posedge clk) begin
        if (clr) begin
            ready <= 1'b0;
            ptr_q <= '0;
            len_q <= '0;
        end else if (load) begin
            ready <= 1'b1;
            ptr_q <= '0;
            len_q <= load_len;
        end else if (pop && ready) begin
            if (last) begin
                ready <= 1'b0;
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_copy
        always_ff @(posedge clk) begin
            if (load && !clr) begin
                mem[g] <= load_data[g];
            end
        end
    end

endmodule

// File: rtl/objx_engine.sv
module objx_engine
    import objx_pkg::*;
#(
    parameter int RESP_LAT  = 4,
    parameter int ABORT_CYC = 6,
    localparam int MAXC = (RESP_LAT > ABORT_CYC) ? RESP_LAT : ABORT_CYC,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic abort_req,
    output logic busy,
    output logic aborting,
    output logic complete,
    output logic abort_done
);

    eng_e          state_q;
    logic [CW-1:0] cnt_q;

    assign busy       = (state_q != ENG_IDLE);
    assign aborting   = (state_q == ENG_ABORT);
    assign complete   = (state_q == ENG_RUN) && (cnt_q == '0) && !abort_req;
    assign abort_done = aborting && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (abort_req) begin
                        state_q <= ENG_ABORT;
                        cnt_q   <= CW'(ABORT_CYC - 1);
                    end else if (start) begin
                        state_q <= ENG_RUN;
                        cnt_q   <= CW'(RESP_LAT - 1);
                    end
                end
                ENG_RUN: begin
                    if (abort_req) begin
                        state_q <= ENG_ABORT;
                        cnt_q   <= CW'(ABORT_CYC - 1);
                    end else if (cnt_q == '0) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ENG_ABORT: begin
                    if (cnt_q == '0) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/objx_irq.sv
module objx_irq (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic ready,
    input  logic error,
    input  logic busy,
    input  logic clr_req,
    output logic irq,
    output logic int_st
);

    logic ready_q, error_q, busy_q;
    logic evt;

    assign evt = (ready && !ready_q) || (error && !error_q) || (busy_q && !busy);

    always_ff @(posedge clk) begin
        if (clr) begin
            ready_q <= 1'b0;
            error_q <= 1'b0;
            busy_q  <= 1'b0;
            irq     <= 1'b0;
            int_st  <= 1'b0;
        end else begin
            ready_q <= ready;
            error_q <= error;
            busy_q  <= busy;
            irq     <= en && evt;
            if (en && evt) begin
                int_st <= 1'b1;
            end else if (clr_req) begin
                int_st <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox
    import objx_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int RESP_LAT  = 4,
    parameter int ABORT_CYC = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        func_rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    sel_e             sel;
    logic             clr;
    logic             wr_ctrl, wr_stat, wr_wmb, wr_rmb;
    logic             abort_req, go, go_ok, go_bad;
    logic             busy, aborting, complete, abort_done;
    logic             ready, error_q, ien_q, int_st;
    logic             clr_req, discard;
    logic [CNT_W-1:0] req_cnt;
    logic             req_ovf;
    logic [DW-1:0]    req_data [DEPTH];
    logic [DW-1:0]    resp_cur;
    stat_t            stat;

    assign sel     = sel_e'(reg_addr);
    assign clr     = rst || func_rst;
    assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
    assign wr_stat = reg_wr && (sel == SEL_STAT);
    assign wr_wmb  = reg_wr && (sel == SEL_WMB);
    assign wr_rmb  = reg_wr && (sel == SEL_RMB);

    assign abort_req = wr_ctrl && reg_wdata[CTL_ABORT];
    assign go        = wr_ctrl && reg_wdata[CTL_GO] && !reg_wdata[CTL_ABORT];
    assign go_ok     = go && !busy && !req_ovf && (req_cnt >= CNT_W'(2));
    assign go_bad    = go && !go_ok;
    assign discard   = (go_bad && !busy) || complete || abort_done;
    assign clr_req   = wr_stat && reg_wdata[STAT_INT];

    objx_req_buf #(.DEPTH(DEPTH)) u_req (
        .clk     (clk),
        .clr     (clr),
        .push    (wr_wmb && !busy),
        .din     (reg_wdata),
        .discard (discard),
        .count   (req_cnt),
        .ovf     (req_ovf),
        .data    (req_data)
    );

    objx_engine #(.RESP_LAT(RESP_LAT), .ABORT_CYC(ABORT_CYC)) u_eng (
        .clk        (clk),
        .clr        (clr),
        .start      (go_ok),
        .abort_req  (abort_req),
        .busy       (busy),
        .aborting   (aborting),
        .complete   (complete),
        .abort_done (abort_done)
    );

    objx_resp_buf #(.DEPTH(DEPTH)) u_resp (
        .clk       (clk),
        .clr       (clr || abort_done),
        .load      (complete),
        .load_data (req_data),
        .load_len  (req_cnt),
        .pop       (wr_rmb),
        .ready     (ready),
        .cur       (resp_cur)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            error_q <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ien_q <= reg_wdata[CTL_IEN];
            end
            if (abort_done) begin
                error_q <= 1'b0;
            end else if (go_bad) begin
                error_q <= 1'b1;
            end
        end
    end

    objx_irq u_irq (
        .clk     (clk),
        .clr     (clr),
        .en      (ien_q),
        .ready   (ready),
        .error   (error_q),
        .busy    (busy),
        .clr_req (clr_req),
        .irq     (irq),
        .int_st  (int_st)
    );

    always_comb begin
        stat.ready  = ready;
        stat.error  = error_q;
        stat.int_st = int_st;
        stat.busy   = busy;
        unique case (sel)
            SEL_CTRL: reg_rdata = ctrl_word(ien_q);
            SEL_STAT: reg_rdata = stat_word(stat);
            SEL_RMB:  reg_rdata = resp_cur;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/objx_mailbox_chk.sv
module objx_mailbox_chk (
    input logic clk,
    input logic rst,
    input logic func_rst,
    input logic irq,
    input logic ien,
    input logic int_st,
    input logic clr_req,
    input logic ready,
    input logic error,
    input logic busy,
    input logic pop,
    input logic abort_done
);

    assert_ready_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(pop || abort_done || func_rst));

    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (rst)
        $past(abort_done) |-> (!ready && !error && !busy));

    assert_int_kept_R7: assert property (@(posedge clk) disable iff (rst)
        $past(int_st && !clr_req && !func_rst) |-> int_st);

    assert_func_rst_R8: assert property (@(posedge clk) disable iff (rst)
        func_rst |=> (!ready && !busy && !error && !int_st && !ien));

    assert_irq_sets_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> int_st);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ien));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_req) && !irq) |-> !int_st);

endmodule

bind objx_mailbox objx_mailbox_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .func_rst   (func_rst),
    .irq        (irq),
    .ien        (ien_q),
    .int_st     (int_st),
    .clr_req    (clr_req),
    .ready      (ready),
    .error      (error_q),
    .busy       (busy),
    .pop        (wr_rmb),
    .abort_done (abort_done)
);

// File: tb/objx_mailbox_test.sv
module objx_mailbox_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LAT        = 4;
    localparam int ABT        = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        func_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int unsigned checks = 0;
    int unsigned failures = 0;
    int unsigned irq_cnt = 0;
    logic        en_sh = 1'b0;
    logic [31:0] exp_q [$];

    objx_mailbox #(.DEPTH(DEPTH), .RESP_LAT(LAT), .ABORT_CYC(ABT)) uut (
        .clk(clk), .rst(rst), .func_rst(func_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input logic go_b, input logic ab_b);
        return {29'd0, en_sh, go_b, ab_b};
    endfunction

    task automatic stat_bit(input string req, input int b, input logic e);
        logic [31:0] s;
        rd(2'd1, s);
        check(req, {31'd0, s[b]}, {31'd0, e});
    endtask

    // driver: writes a request and pushes its expected echo into the scoreboard
    task automatic send_req(input int n, input logic [31:0] seed, input bit expect_resp);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = (i == 1) ? 32'(n) : seed + 32'(i);
            wr(2'd2, w);
            if (expect_resp) exp_q.push_back(w);
        end
    endtask

    // monitor: pops expected dwords and compares them with the read mailbox
    task automatic drain(input string req);
        logic [31:0] d;
        while (exp_q.size() > 0) begin
            stat_bit(req, 3, 1'b1);
            rd(2'd3, d);
            check(req, d, exp_q.pop_front());
            wr(2'd3, 32'hFFFF_FFFF);
        end
        stat_bit(req, 3, 1'b0);
    endtask

    task automatic wait_ready(input string req);
        logic [31:0] s;
        int n = 0;
        rd(2'd1, s);
        while (!s[3] && n < 50) begin
            @(negedge clk);
            n++;
            rd(2'd1, s);
        end
        check(req, {31'd0, s[3]}, 32'd1);
    endtask

    task automatic do_abort(input string req);
        wr(2'd0, ctl(1'b0, 1'b1));
        stat_bit(req, 0, 1'b1);
        repeat (ABT - 1) @(negedge clk);
        stat_bit(req, 0, 1'b1);
        @(negedge clk);
        stat_bit(req, 0, 1'b0);
        stat_bit(req, 2, 1'b0);
        stat_bit(req, 3, 1'b0);
    endtask

    initial begin
        logic [31:0] d;
        int unsigned c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 32'd0);
        rd(2'd1, d); check("R1 status", d, 32'd0);
        rd(2'd3, d); check("R1 rmbox", d, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2, R3, R9, R11: normal transfer with interrupts enabled
        en_sh = 1'b1;
        wr(2'd0, ctl(1'b0, 1'b0));
        rd(2'd0, d); check("R9 enable readback", d, 32'd4);
        send_req(3, 32'hA5A5_0000, 1'b1);
        wr(2'd0, ctl(1'b1, 1'b0));
        stat_bit("R2 busy after go", 0, 1'b1);
        wr(2'd2, 32'hDEAD_BEEF);                 // R11: ignored while busy
        repeat (LAT - 2) @(negedge clk);
        stat_bit("R2 busy held", 0, 1'b1);
        stat_bit("R2 not ready yet", 3, 1'b0);
        @(negedge clk);
        stat_bit("R2 ready", 3, 1'b1);
        stat_bit("R2 busy cleared", 0, 1'b0);
        check("R9 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R9 irq pulse", {31'd0, irq}, 32'd1);
        stat_bit("R9 int status", 1, 1'b1);
        @(negedge clk);
        check("R9 irq one cycle", {31'd0, irq}, 32'd0);
        drain("R3 R11 echo");
        rd(2'd3, d); check("R4 rmbox zero", d, 32'd0);
        wr(2'd3, 32'd5);
        rd(2'd1, d); check("R4 pop ignored", d & 32'hD, 32'd0);

        // R10 clear
        wr(2'd1, 32'd2);
        stat_bit("R10 w1c", 1, 1'b0);

        // R5 short request, R7 abort keeps int status
        send_req(1, 32'h1111_0000, 1'b0);
        wr(2'd0, ctl(1'b1, 1'b0));
        stat_bit("R5 short go error", 2, 1'b1);
        @(negedge clk);
        check("R9 error irq", {31'd0, irq}, 32'd1);
        en_sh = 1'b0;
        wr(2'd0, ctl(1'b0, 1'b0));
        do_abort("R6 abort");
        @(negedge clk);
        stat_bit("R7 int kept", 1, 1'b1);
        check("R9 gated irq", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'd2);

        // R5 overflow
        en_sh = 1'b1;
        wr(2'd0, ctl(1'b0, 1'b0));
        send_req(DEPTH + 1, 32'h2222_0000, 1'b0);
        wr(2'd0, ctl(1'b1, 1'b0));
        stat_bit("R5 overflow error", 2, 1'b1);
        do_abort("R6 abort after overflow");
        @(negedge clk);
        check("R9 busy-clear irq", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'd2);

        // R5 go while busy keeps in-flight request
        send_req(2, 32'h3333_0000, 1'b1);
        wr(2'd0, ctl(1'b1, 1'b0));
        wr(2'd0, ctl(1'b1, 1'b0));
        stat_bit("R5 go while busy error", 2, 1'b1);
        wait_ready("R5 in-flight completes");
        drain("R5 in-flight intact");
        do_abort("R6 abort clears error");
        repeat (2) @(negedge clk);
        wr(2'd1, 32'd2);

        // R10 collision: clear lands on the edge that sets int status
        send_req(3, 32'h4444_0000, 1'b1);
        wr(2'd0, ctl(1'b1, 1'b0));
        repeat (LAT) @(negedge clk);
        wr(2'd1, 32'd2);
        stat_bit("R10 set wins", 1, 1'b1);
        wr(2'd1, 32'd2);
        stat_bit("R10 cleared", 1, 1'b0);
        drain("R3 echo after collision");

        // R8 function reset mid-response
        send_req(4, 32'h5555_0000, 1'b1);
        wr(2'd0, ctl(1'b1, 1'b0));
        wait_ready("R8 ready before reset");
        rd(2'd3, d); check("R8 first dword", d, exp_q.pop_front());
        wr(2'd3, 32'd0);
        func_rst = 1'b1;
        @(negedge clk);
        func_rst = 1'b0;
        exp_q.delete();
        rd(2'd1, d); check("R8 status cleared", d, 32'd0);
        rd(2'd3, d); check("R8 rmbox zero", d, 32'd0);
        rd(2'd0, d); check("R8 enable cleared", d, 32'd0);

        // R9 disabled interrupts
        en_sh = 1'b0;
        c0 = irq_cnt;
        send_req(2, 32'h6666_0000, 1'b1);
        wr(2'd0, ctl(1'b1, 1'b0));
        wait_ready("R9 disabled ready");
        repeat (2) @(negedge clk);
        check("R9 no irq when disabled", irq_cnt, c0);
        stat_bit("R9 no int status when disabled", 1, 1'b0);
        drain("R3 echo disabled");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule